// File: doc/BRIEF.md
# Inter-processor doorbell interrupt controller

This block gives software on any core of a cluster a way to interrupt any group of that cluster's cores. It holds several independent doorbell sets, eight by default. Each set has a write-to-fire trigger register and an enable mask. Both registers carry one bit per destination core: bits 0 to 15 address the compute cores and bit 16 addresses the cluster's resource-manager core.

A write to a set's trigger register produces a one-cycle pulse toward each destination whose bit is set in both the written word and that set's mask. Nothing is left pending, so a trigger sent to a disabled core is lost. The block sits on a simple synchronous register bus inside a 4 KiB window. Writes take effect at the clock edge, and read data follows the address combinationally.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset every mask reads as zero and every interrupt output is low.
- R2: Set s has its mask at byte offset s*8+4. A write there stores data bits 16:0, which are then read back with bits 31:17 as zero. The mask keeps its value until that set's mask is written again.
- R3: Set s has its trigger at byte offset s*8+0, and reading it always returns zero.
- R4: In the cycle after a trigger write to set s, output bit s*17+k is high for every k set in both the written data and the mask of set s. In the following cycle it is low again, unless that set is written again.
- R5: A trigger to a core whose mask bit is clear is dropped. Setting the mask bit afterwards produces no interrupt.
- R6: Bit 16 of both registers addresses the resource-manager core, output s*17+16, and is gated like the compute-core bits.
- R7: An address at or above byte offset 0x40, or one whose bits 1:0 are not zero, reads as zero. A write to such an address changes no mask and fires no interrupt.
- R8: Trigger writes to different sets in consecutive cycles each give their own one-cycle pulse on their own outputs.
- R9: A mask write to one set leaves the masks of all other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_out | output | 136 | Interrupt pulses, bit s*17+k for set s and destination k |

## Verification
The bench uses the default parameters: eight sets of seventeen destinations. With these values the resource-manager bit 16, the last set at offset 0x38 and the first unmapped offset 0x40 can all be reached. The full 136-bit output vector is compared after every write, so a pulse that leaks into a neighbouring set or a neighbouring destination would be caught. A seeded random mix of mask writes, triggers and stray addresses runs alongside directed cases for dropped triggers, back-to-back sets and reads of misaligned addresses.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;
  localparam int unsigned MAX_DEST = 32;

  typedef enum logic {
    REG_TRIG = 1'b0,
    REG_MASK = 1'b1
  } reg_kind_e;

  // destinations that actually receive a pulse
  function automatic logic [MAX_DEST-1:0] fire_bits(
    input logic [MAX_DEST-1:0] request,
    input logic [MAX_DEST-1:0] enable
  );
    return request & enable;
  endfunction
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_SETS = 8,
  localparam int unsigned SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_kind_e         kind,
  output logic [SET_W-1:0]  set_idx
);
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(NUM_SETS * 8);

  always_comb begin
    hit     = (addr < MAP_END) && (addr[1:0] == 2'b00);
    kind    = addr[2] ? REG_MASK : REG_TRIG;
    set_idx = SET_W'(addr >> 3);
  end
endmodule

// File: rtl/ipi_doorbell_set.sv
module ipi_doorbell_set
  import ipi_doorbell_pkg::*;
#(
  parameter int unsigned NUM_DEST = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mask_wr,
  input  logic                trig_fire,
  input  logic [NUM_DEST-1:0] wdata,
  output logic [NUM_DEST-1:0] mask_q,
  output logic [NUM_DEST-1:0] irq_q
);
  logic [NUM_DEST-1:0] fire_now;
  logic [MAX_DEST-1:0] fire_wide;

  assign fire_wide = fire_bits(MAX_DEST'(wdata), MAX_DEST'(mask_q));
  assign fire_now  = fire_wide[NUM_DEST-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      irq_q <= trig_fire ? fire_now : '0;
    end
  end

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R4
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_fire |=> irq_q == '0);

  // R5
  masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> (irq_q & ~$past(mask_q)) == '0);

  // R4
  pulse_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> (irq_q & ~$past(wdata)) == '0);
endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
  import ipi_doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SETS = 8,
  parameter int unsigned NUM_DEST = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic [NUM_SETS*NUM_DEST-1:0] irq_out
);
  localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  logic             dec_hit;
  reg_kind_e        dec_kind;
  logic [SET_W-1:0] dec_set;
  logic             wr_mask_any;
  logic             wr_trig_any;
  logic [NUM_DEST-1:0] mask_all [NUM_SETS];
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_DEST];

  ipi_addr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_SETS(NUM_SETS)
  ) i_decode (
    .addr   (bus_addr),
    .hit    (dec_hit),
    .kind   (dec_kind),
    .set_idx(dec_set)
  );

  assign wr_mask_any = bus_we && dec_hit && (dec_kind == REG_MASK);
  assign wr_trig_any = bus_we && dec_hit && (dec_kind == REG_TRIG);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic sel;
    assign sel = (dec_set == SET_W'(s));

    ipi_doorbell_set #(
      .NUM_DEST(NUM_DEST)
    ) i_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_wr  (wr_mask_any && sel),
      .trig_fire(wr_trig_any && sel),
      .wdata    (bus_wdata[NUM_DEST-1:0]),
      .mask_q   (mask_all[s]),
      .irq_q    (irq_out[s*NUM_DEST +: NUM_DEST])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (dec_hit && dec_kind == REG_MASK)
      bus_rdata[NUM_DEST-1:0] = mask_all[dec_set];
  end

  // R7
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> bus_rdata == '0);

  // R3
  trig_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit && dec_kind == REG_TRIG) |-> bus_rdata == '0);

  // R7
  unmapped_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && dec_hit) |=> irq_out == '0);

  // R8
  single_set_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(irq_out) <= NUM_DEST);
endmodule

// File: tb/test_ipi_doorbell.sv
module test_ipi_doorbell;
  localparam int NS = 8;
  localparam int ND = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NS*ND-1:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [ND-1:0] mdl [NS];

  always #5 clk = ~clk;

  ipi_doorbell i_ipi_doorbell (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic bit is_mapped(input logic [11:0] a);
    return (a < 12'h040) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (!is_mapped(a) || !a[2]) return 32'h0;
    return {15'h0, mdl[a[5:3]]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NS*ND-1:0] act,
                     input logic [NS*ND-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call at negedge; returns at the next negedge with irq checked
  task automatic do_write(input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [NS*ND-1:0] exp;
    exp = '0;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    if (is_mapped(a)) begin
      if (a[2]) mdl[a[5:3]] = d[ND-1:0];
      else exp[a[5:3]*ND +: ND] = d[ND-1:0] & mdl[a[5:3]];
    end
    chk(irq_out == exp, tag, irq_out, exp);
  endtask

  task automatic read_chk(input logic [11:0] a, input string tag);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata == exp_read(a), tag, NS*ND'(bus_rdata), NS*ND'(exp_read(a)));
  endtask

  task automatic idle_chk(input string tag);
    bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(irq_out == '0, tag, irq_out, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < NS; s++) mdl[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_out == '0, "R1 irq after reset", irq_out, '0);
    for (int s = 0; s < NS; s++) read_chk(12'(s*8+4), "R1 mask after reset");

    // R2 mask write and readback, upper bits dropped
    do_write(12'h004, 32'hFFFF_FFFF, "R2 mask write no irq");
    read_chk(12'h004, "R2 mask readback");
    // R3 trigger reads zero
    read_chk(12'h000, "R3 trigger read");
    @(negedge clk);

    // R4 pulse and return to zero
    do_write(12'h000, 32'h0000_0005, "R4 trigger pulse");
    idle_chk("R4 pulse ends");

    // R6 resource-manager bit only
    do_write(12'h01C, 32'h0001_0000, "R6 mask rm bit");
    do_write(12'h018, 32'h0001_FFFF, "R6 rm pulse only");
    idle_chk("R6 pulse ends");

    // R5 masked trigger dropped, not pending
    do_write(12'h028, 32'h0000_00FF, "R5 masked trigger");
    do_write(12'h02C, 32'h0000_00FF, "R5 enable later");
    idle_chk("R5 nothing pending");

    // R7 unmapped and misaligned
    do_write(12'h040, 32'hFFFF_FFFF, "R7 write 0x40");
    do_write(12'h001, 32'h0000_0000, "R7 misaligned write");
    do_write(12'h006, 32'h0000_0000, "R7 misaligned mask write");
    read_chk(12'h004, "R7 mask untouched");
    read_chk(12'h040, "R7 read 0x40");
    read_chk(12'h005, "R7 misaligned read");
    read_chk(12'hFFC, "R7 read top");
    @(negedge clk);

    // R8 back-to-back sets
    do_write(12'h000, 32'h0001_FFFF, "R8 first set");
    do_write(12'h018, 32'h0001_FFFF, "R8 second set");
    do_write(12'h000, 32'h0000_0002, "R8 third write");
    idle_chk("R8 quiet after");

    // R9 set isolation
    do_write(12'h034, 32'h0000_1234, "R9 set6 mask");
    do_write(12'h03C, 32'h0000_ABCD, "R9 set7 mask");
    read_chk(12'h034, "R9 set6 unchanged");
    read_chk(12'h03C, "R9 set7 value");
    @(negedge clk);

    // random mix: R2 R4 R7 R8
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int r;
      r = int'($urandom % 10);
      if (r == 0) a = 12'($urandom);
      else a = 12'((($urandom % NS) * 8) + (($urandom % 2) * 4));
      d = $urandom;
      if (r > 6) d = d & 32'h0001_0000 | (d & 32'h0000_000F);
      do_write(a, d, "R4 random write");
      if ((i % 8) == 0) begin
        read_chk(12'((($urandom % NS) * 8) + 4), "R2 random readback");
        @(negedge clk);
      end
    end
    idle_chk("R4 final quiet");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule